// File: doc/BRIEF.md
# External Bus Strobe and Address Sequencer

This block produces the timing strobes and pin values of the external memory bus of an 8-bit microcontroller. It is clocked by the oscillator. A machine cycle is twelve oscillator clocks, and a phase counter driven by the surrounding logic marks each clock with a number from 0 to 11. For each phase the block decides whether the address-latch strobe is high and whether the active-low program-store strobe is asserted. It also decides what the multiplexed low address/data port drives, whether that port is released, and which byte goes out on the high address port.

The strobes run at a fixed rate. They are thinned during an external data access. A control bit can restrict the address-latch strobe to data-move and code-table cycles, and an external-execution flag overrides that bit. A reset input is qualified by a counter, so a short glitch never resets the bus. While the qualified reset is active, every strobe and driver is held idle. Every output is registered and follows the phase input by one clock.

Top module: `bus_strobe_seq`

## Requirements
- R1: One clock after phase 0, 1, 6 or 7 is presented, `ale` is 1 when the latch strobe is enabled and no data access is in progress. It is 0 after every other phase.
- R2: While `xdata_req` is 1, `ale` is 1 only after phases 0 and 1. The pulse at phases 6–7 is omitted.
- R3: With `code_ext`=1 and `xdata_req`=0, `psen_n` is 0 one clock after phases 3–5 and 9–11, and 1 after all other phases. With `code_ext`=0, `psen_n` stays 1.
- R4: While `xdata_req` is 1, `psen_n` stays 1 for the whole machine cycle, so both strobe pulses are omitted.
- R5: With `ale_off`=1 and `ext_exec`=0, `ale` stays 0 unless `xdata_req` or `movc_req` is 1. In those cycles it follows R1/R2.
- R6: With `ext_exec`=1, `ale_off` has no effect on `ale`.
- R7: `a_hi` carries `addr_hi` during a code fetch (`code_ext`=1) and during a wide data access (`xdata_req`=1, `xdata_wide`=1). In all other cycles, including a narrow data access, it carries `p2_latch`.
- R8: In a data access, the low port drives `addr_lo` after phases 0–2. After phases 3–11 it drives `wdata` when `xdata_wr`=1 and is released otherwise. In a code fetch without a data access, it drives `addr_lo` after phases 0–2 and 6–8 and is released after the rest. When the port is released, `ad_oe`=0 and `ad_out`=0.
- R9: On the clock where phase 11 of a data read (`xdata_req`=1, `xdata_wr`=0) is presented, `bus_in` is captured into `rdata` and `rdata_vld` is 1 for exactly that following clock.
- R10: `sys_rst` becomes 1 after `rst_pin` has been high for 24 consecutive rising edges. It returns to 0 on the first edge at which `rst_pin` is low, and the count restarts from zero.
- R11: On each edge at which `sys_rst` is 1, the registered outputs go idle: `ale`=0, `psen_n`=1, `ad_oe`=0, `ad_out`=0, `rdata_vld`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset input, active high |
| phase | input | 4 | Machine-cycle phase, 0 to 11 |
| code_ext | input | 1 | Code is fetched from external program memory |
| xdata_req | input | 1 | External data access in this machine cycle |
| xdata_wide | input | 1 | Data access uses a 16-bit address |
| xdata_wr | input | 1 | Data access is a write |
| movc_req | input | 1 | Code-table read in this machine cycle |
| ale_off | input | 1 | Control bit limiting the latch strobe to data/table cycles |
| ext_exec | input | 1 | Device runs in external execution mode |
| addr_lo | input | 8 | Low address byte |
| addr_hi | input | 8 | High address byte |
| p2_latch | input | 8 | Contents of the high port's own latch |
| wdata | input | 8 | Write data for a data access |
| bus_in | input | 8 | Value read from the low port pins |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| ad_out | output | 8 | Value driven on the low port |
| ad_oe | output | 1 | Low port drive enable |
| a_hi | output | 8 | High address port value |
| rdata | output | 8 | Captured read data |
| rdata_vld | output | 1 | Read data captured on the previous edge |
| sys_rst | output | 1 | Qualified reset |

## Verification
Strobes, port values and the high byte are due one clock after their phase is presented. The bench therefore drives the phase at a falling edge and compares just after the next rising edge. Read capture lands on the edge that samples phase 11, so `rdata_vld` is checked on the step after phase 11 and against a model flag that the bench sets when it presents that phase. The reset qualifier is checked on the 23rd and 24th edges of a held `rst_pin` and on the first edge after release. The idle behaviour is checked one edge after `sys_rst` is seen high.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int DW      = 8;
    localparam int PW      = 4;
    localparam int PH_N    = 12;
    localparam int HOLD_CK = 2 * PH_N;

    typedef struct packed {
        logic          ale;
        logic          psen_n;
        logic [DW-1:0] ad_out;
        logic          ad_oe;
        logic [DW-1:0] a_hi;
        logic [DW-1:0] rdata;
        logic          rdv;
    } bus_st_t;
endpackage

// File: rtl/bss_rst_qual.sv
module bss_rst_qual #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst_pin,
    output logic sys_rst
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] CMAX = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!rst_pin)          cnt_d = '0;
        else if (cnt_q == CMAX) cnt_d = cnt_q;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) cnt_q <= cnt_d;

    assign sys_rst = (cnt_q == CMAX);
endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen #(
    parameter int PW = 4
) (
    input  logic [PW-1:0] phase,
    input  logic          code_ext,
    input  logic          xdata_req,
    input  logic          movc_req,
    input  logic          ale_off,
    input  logic          ext_exec,
    output logic          ale_win,
    output logic          psen_win,
    output logic          addr_win,
    output logic          data_win,
    output logic          sample_pt
);
    logic first_half_addr, second_half_addr, read_half, ale_slot, ale_gate;

    always_comb begin
        first_half_addr  = (phase <= PW'(2));
        second_half_addr = (phase >= PW'(6)) && (phase <= PW'(8));
        read_half        = ((phase >= PW'(3)) && (phase <= PW'(5))) ||
                           ((phase >= PW'(9)) && (phase <= PW'(11)));
        ale_slot         = (phase <= PW'(1)) ||
                           (!xdata_req && (phase == PW'(6) || phase == PW'(7)));
        ale_gate         = !ale_off || ext_exec || xdata_req || movc_req;

        ale_win   = ale_slot && ale_gate;
        psen_win  = code_ext && !xdata_req && read_half;
        addr_win  = first_half_addr || (!xdata_req && code_ext && second_half_addr);
        data_win  = xdata_req && (phase >= PW'(3)) && (phase <= PW'(11));
        sample_pt = xdata_req && (phase == PW'(11));
    end
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
    import bss_pkg::*;
(
    input  logic          clk,
    input  logic          rst_pin,
    input  logic [PW-1:0] phase,
    input  logic          code_ext,
    input  logic          xdata_req,
    input  logic          xdata_wide,
    input  logic          xdata_wr,
    input  logic          movc_req,
    input  logic          ale_off,
    input  logic          ext_exec,
    input  logic [DW-1:0] addr_lo,
    input  logic [DW-1:0] addr_hi,
    input  logic [DW-1:0] p2_latch,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_in,
    output logic          ale,
    output logic          psen_n,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic [DW-1:0] a_hi,
    output logic [DW-1:0] rdata,
    output logic          rdata_vld,
    output logic          sys_rst
);
    bus_st_t st_d, st_q;
    logic ale_win, psen_win, addr_win, data_win, sample_pt;

    bss_rst_qual #(.HOLD(HOLD_CK)) i_rq (
        .clk     (clk),
        .rst_pin (rst_pin),
        .sys_rst (sys_rst)
    );

    bss_strobe_gen #(.PW(PW)) i_sg (
        .phase     (phase),
        .code_ext  (code_ext),
        .xdata_req (xdata_req),
        .movc_req  (movc_req),
        .ale_off   (ale_off),
        .ext_exec  (ext_exec),
        .ale_win   (ale_win),
        .psen_win  (psen_win),
        .addr_win  (addr_win),
        .data_win  (data_win),
        .sample_pt (sample_pt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ale    = ale_win;
        st_d.psen_n = !psen_win;
        st_d.rdv    = 1'b0;
        st_d.ad_oe  = 1'b0;
        st_d.ad_out = '0;
        if ((xdata_req || code_ext) && addr_win) begin
            st_d.ad_oe  = 1'b1;
            st_d.ad_out = addr_lo;
        end else if (data_win && xdata_wr) begin
            st_d.ad_oe  = 1'b1;
            st_d.ad_out = wdata;
        end
        if (xdata_req)      st_d.a_hi = xdata_wide ? addr_hi : p2_latch;
        else if (code_ext)  st_d.a_hi = addr_hi;
        else                st_d.a_hi = p2_latch;
        if (sample_pt && !xdata_wr) begin
            st_d.rdata = bus_in;
            st_d.rdv   = 1'b1;
        end
        if (sys_rst) begin
            st_d.ale    = 1'b0;
            st_d.psen_n = 1'b1;
            st_d.ad_oe  = 1'b0;
            st_d.ad_out = '0;
            st_d.rdata  = '0;
            st_d.rdv    = 1'b0;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign ale       = st_q.ale;
    assign psen_n    = st_q.psen_n;
    assign ad_out    = st_q.ad_out;
    assign ad_oe     = st_q.ad_oe;
    assign a_hi      = st_q.a_hi;
    assign rdata     = st_q.rdata;
    assign rdata_vld = st_q.rdv;
endmodule

// File: rtl/bus_strobe_seq_chk.sv
module bus_strobe_seq_chk (
    input logic       clk,
    input logic       rst_pin,
    input logic [3:0] phase,
    input logic       code_ext,
    input logic       xdata_req,
    input logic       xdata_wr,
    input logic       movc_req,
    input logic       ale_off,
    input logic       ext_exec,
    input logic       ale,
    input logic       psen_n,
    input logic       ad_oe,
    input logic       rdata_vld,
    input logic       sys_rst
);
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (sys_rst)
        !(ale && !psen_n));

    p_ale_skip_r2: assert property (@(posedge clk) disable iff (sys_rst)
        (xdata_req && phase == 4'd6) |=> !ale);

    p_psen_hold_r4: assert property (@(posedge clk) disable iff (sys_rst)
        xdata_req |=> psen_n);

    p_ale_gated_r5: assert property (@(posedge clk) disable iff (sys_rst)
        (ale_off && !ext_exec && !xdata_req && !movc_req) |=> !ale);

    p_ale_ext_r6: assert property (@(posedge clk) disable iff (sys_rst)
        (ext_exec && phase == 4'd0) |=> ale);

    p_rdv_src_r9: assert property (@(posedge clk) disable iff (sys_rst)
        (xdata_req && !xdata_wr && phase == 4'd11) |=> rdata_vld);

    p_rst_hold_r10: assert property (@(posedge clk) disable iff (!rst_pin)
        $rose(sys_rst) |-> $past(rst_pin));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_pin)
        sys_rst |=> (!ale && psen_n && !ad_oe && !rdata_vld));
endmodule

bind bus_strobe_seq bus_strobe_seq_chk i_chk (
    .clk       (clk),
    .rst_pin   (rst_pin),
    .phase     (phase),
    .code_ext  (code_ext),
    .xdata_req (xdata_req),
    .xdata_wr  (xdata_wr),
    .movc_req  (movc_req),
    .ale_off   (ale_off),
    .ext_exec  (ext_exec),
    .ale       (ale),
    .psen_n    (psen_n),
    .ad_oe     (ad_oe),
    .rdata_vld (rdata_vld),
    .sys_rst   (sys_rst)
);

// File: tb/test_bus_strobe_seq.sv
module test_bus_strobe_seq;
    logic       clk = 1'b0;
    logic       rst_pin = 1'b0;
    logic [3:0] phase = '0;
    logic       code_ext = 0, xdata_req = 0, xdata_wide = 0, xdata_wr = 0;
    logic       movc_req = 0, ale_off = 0, ext_exec = 0;
    logic [7:0] addr_lo = '0, addr_hi = '0, p2_latch = '0, wdata = '0, bus_in = '0;
    logic       ale, psen_n, ad_oe, rdata_vld, sys_rst;
    logic [7:0] ad_out, a_hi, rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    bus_strobe_seq i_bus_strobe_seq (
        .clk(clk), .rst_pin(rst_pin), .phase(phase), .code_ext(code_ext),
        .xdata_req(xdata_req), .xdata_wide(xdata_wide), .xdata_wr(xdata_wr),
        .movc_req(movc_req), .ale_off(ale_off), .ext_exec(ext_exec),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .p2_latch(p2_latch),
        .wdata(wdata), .bus_in(bus_in), .ale(ale), .psen_n(psen_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .rdata(rdata),
        .rdata_vld(rdata_vld), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic e_ale, e_psen, e_oe, e_vld;
        logic [7:0] e_ad, e_hi, e_rd;
        e_rd = '0;
        @(negedge clk);
        step();
        chk("R10 reset low", sys_rst, 0);

        // R10: 24 held edges qualify the reset
        @(negedge clk); rst_pin = 1;
        for (int i = 1; i <= 24; i++) begin
            step();
            if (i == 23) chk("R10 edge 23", sys_rst, 0);
            if (i == 24) chk("R10 edge 24", sys_rst, 1);
        end
        // R11: outputs idle one edge later, phase 0 with fetch enabled
        @(negedge clk); code_ext = 1; phase = 4'd0;
        step();
        chk("R11 ale idle", ale, 0);
        chk("R11 oe idle", ad_oe, 0);
        chk("R11 rdata idle", rdata, 0);
        @(negedge clk); phase = 4'd3;
        step();
        chk("R11 psen idle", psen_n, 1);
        @(negedge clk); rst_pin = 0;
        step();
        chk("R10 release", sys_rst, 0);
        // R10: glitch of 10 clocks does not reset, counter restarts
        @(negedge clk); rst_pin = 1;
        for (int i = 0; i < 10; i++) step();
        @(negedge clk); rst_pin = 0;
        step();
        @(negedge clk); rst_pin = 1;
        for (int i = 1; i <= 23; i++) step();
        chk("R10 restart 23", sys_rst, 0);
        @(negedge clk); rst_pin = 0;
        step();

        // Sweep of every control combination across every phase
        e_vld = 0;
        for (int c = 0; c < 128; c++) begin
            for (int p = 0; p < 12; p++) begin
                @(negedge clk);
                {ext_exec, ale_off, movc_req, xdata_wr, xdata_wide, xdata_req, code_ext} = 7'(c);
                phase    = 4'(p);
                addr_lo  = 8'(c * 3 + p);
                addr_hi  = 8'(c ^ 8'h5A);
                p2_latch = 8'(c + 8'h80);
                wdata    = 8'(~(c + p));
                bus_in   = 8'(c * 7 + 1);
                e_ale  = (!ale_off || ext_exec || xdata_req || movc_req) &&
                         (p <= 1 || (!xdata_req && (p == 6 || p == 7)));
                e_psen = !(code_ext && !xdata_req && ((p >= 3 && p <= 5) || p >= 9));
                e_oe = 0; e_ad = '0;
                if (xdata_req) begin
                    if (p <= 2) begin e_oe = 1; e_ad = addr_lo; end
                    else if (xdata_wr) begin e_oe = 1; e_ad = wdata; end
                end else if (code_ext && (p <= 2 || (p >= 6 && p <= 8))) begin
                    e_oe = 1; e_ad = addr_lo;
                end
                e_hi  = xdata_req ? (xdata_wide ? addr_hi : p2_latch)
                                  : (code_ext ? addr_hi : p2_latch);
                e_vld = xdata_req && !xdata_wr && p == 11;
                if (e_vld) e_rd = bus_in;
                step();
                chk(xdata_req ? "R2 ale" : (ext_exec ? "R6 ale" : (ale_off ? "R5 ale" : "R1 ale")),
                    ale, e_ale);
                chk(xdata_req ? "R4 psen" : "R3 psen", psen_n, e_psen);
                chk("R8 oe", ad_oe, e_oe);
                chk("R8 ad", ad_out, e_ad);
                chk("R7 hi", a_hi, e_hi);
                chk("R9 vld", rdata_vld, e_vld);
                chk("R9 data", rdata, e_rd);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule